// File: doc/BRIEF.md
# Repeated String Transfer Engine

This block is a sequencer that carries out one string instruction element by element: move, compare, scan, load or store, on bytes or 16-bit words, optionally under a repeat prefix. A controller starts it with a one-cycle `start` pulse that presents the operation, the element width, the prefix, the direction flag, the incoming zero flag, the source and destination offsets, the count, both segment bases and the accumulator. The engine then keeps the source offset, destination offset and count in its own registers and works through memory over a byte-wide request/acknowledge port.

Each memory access is one byte. A word element takes two accesses, and the lower address is always accessed first. The physical address is the segment value times sixteen plus the offset, truncated to 20 bits. At the end of the run the engine raises `done` for one cycle. The updated offsets, count, zero flag and accumulator can be read on its outputs, and they hold those values until the next start.

The prefix decides how many elements are processed. Without a prefix, exactly one element is handled and the count is left alone. With a prefix, the count is tested before every element. The two conditional prefixes can also stop the run after a compare or a scan, depending on the zero flag that element produced.

Top module: `strx_engine`

## Requirements
- R1: The source byte address is `src_seg_in*16 + src_off` and the destination byte address is `dst_seg_in*16 + dst_off`. Both are 20 bits wide. The second byte of a word uses offset+1, which wraps within 16 bits.
- R2: After each element, the offsets move by 1 for bytes or 2 for words, upward when `dir_down`=0 and downward when `dir_down`=1. Move, compare and load advance the source offset. Move, compare, scan and store advance the destination offset.
- R3: Words are little-endian. The low byte is at the lower address and is accessed first. Every write reaches the port in element order.
- R4: With `rep_mode` 1 (unconditional), 2 (while equal) or 3 (while not equal), the count is tested before each element. If the count is zero, the run ends with no memory access. Otherwise the count drops by one and one element is processed.
- R5: For compare and scan, prefix 2 stops the run after an element that leaves the zero flag 0, and prefix 3 stops it after an element that leaves the flag 1. For move, load and store, prefixes 2 and 3 behave exactly like prefix 1.
- R6: With `rep_mode` 0, exactly one element is processed and the count is unchanged, whatever its value.
- R7: The operation codes are 0 move, 1 compare, 2 scan, 3 load and 4 store; codes 5 to 7 act as move. Compare sets the zero flag to (source element == destination element). Scan sets it to (accumulator element == destination element), using only the low 8 bits for bytes. Move, load and store keep the incoming zero flag.
- R8: A byte load replaces the low 8 bits of the accumulator and keeps the high 8 bits. A word load replaces all 16 bits. A store writes the accumulator element to the destination.
- R9: After reset the engine is idle, with `busy`, `done` and `mem_req` low and every register zero. `done` is a one-cycle pulse, and `busy` is low in the cycle after it. A request keeps its address and write enable stable until it is acknowledged.
- R10: A `start` pulse that arrives while `busy` is high is ignored and does not change the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch pulse, taken only while idle |
| op_code | input | 3 | Operation: 0 move, 1 compare, 2 scan, 3 load, 4 store |
| word_mode | input | 1 | 1 selects 16-bit elements, 0 selects bytes |
| rep_mode | input | 2 | 0 none, 1 unconditional, 2 while equal, 3 while not equal |
| dir_down | input | 1 | Direction flag: 1 makes the offsets decrement |
| zf_in | input | 1 | Zero flag at launch |
| src_off_in | input | 16 | Initial source offset |
| dst_off_in | input | 16 | Initial destination offset |
| count_in | input | 16 | Initial element count |
| src_seg_in | input | 16 | Source segment base |
| dst_seg_in | input | 16 | Destination segment base |
| acc_in | input | 16 | Accumulator at launch |
| busy | output | 1 | High from launch until the done cycle inclusive |
| done | output | 1 | One-cycle completion pulse |
| zf_out | output | 1 | Current zero flag |
| src_off | output | 16 | Current source offset |
| dst_off | output | 16 | Current destination offset |
| count | output | 16 | Current count |
| acc_out | output | 16 | Current accumulator |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Acknowledge; read data is valid in the same cycle |
| mem_rdata | input | 8 | Read byte |

## Verification
The two end conditions of a conditional prefix, the count running out and a compare mismatch, can fall on the same element. The bench provokes this with a while-equal compare whose count equals the position of the first differing byte plus one, so both conditions occur on the last element. A correct engine then finishes with the count at zero and the zero flag clear, and the offsets advanced exactly once per element processed. The per-cycle reference compares every write address and byte as it is acknowledged. A start pulse injected in the middle of a run must leave that run's writes and final state untouched.

// File: rtl/strx_pkg.sv
package strx_pkg;

    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_CMP   = 3'd1,
        OP_SCAN  = 3'd2,
        OP_LOAD  = 3'd3,
        OP_STORE = 3'd4
    } str_op_e;

    typedef enum logic [1:0] {
        RP_NONE = 2'd0,
        RP_ALL  = 2'd1,
        RP_EQ   = 2'd2,
        RP_NE   = 2'd3
    } rep_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ACCESS,
        ST_STEP,
        ST_DONE
    } st_e;

    typedef enum logic [1:0] {
        PH_SRC,
        PH_DRD,
        PH_DWR
    } ph_e;

    // Which memory phases and pointer updates an operation uses.
    typedef struct packed {
        logic rd_src;
        logic rd_dst;
        logic wr_dst;
        logic sets_zf;
        logic adv_si;
        logic adv_di;
    } op_use_t;

    function automatic op_use_t decode_op(input logic [2:0] code);
        op_use_t u;
        case (code)
            OP_CMP:   u = '{rd_src: 1'b1, rd_dst: 1'b1, wr_dst: 1'b0, sets_zf: 1'b1, adv_si: 1'b1, adv_di: 1'b1};
            OP_SCAN:  u = '{rd_src: 1'b0, rd_dst: 1'b1, wr_dst: 1'b0, sets_zf: 1'b1, adv_si: 1'b0, adv_di: 1'b1};
            OP_LOAD:  u = '{rd_src: 1'b1, rd_dst: 1'b0, wr_dst: 1'b0, sets_zf: 1'b0, adv_si: 1'b1, adv_di: 1'b0};
            OP_STORE: u = '{rd_src: 1'b0, rd_dst: 1'b0, wr_dst: 1'b1, sets_zf: 1'b0, adv_si: 1'b0, adv_di: 1'b1};
            default:  u = '{rd_src: 1'b1, rd_dst: 1'b0, wr_dst: 1'b1, sets_zf: 1'b0, adv_si: 1'b1, adv_di: 1'b1};
        endcase
        return u;
    endfunction

endpackage

// File: rtl/strx_ptr_step.sv
module strx_ptr_step #(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W-1:0] ptr,
    input  logic             wide,
    input  logic             dir_down,
    output logic [OFF_W-1:0] nxt
);
    localparam logic [OFF_W-1:0] STEP_B = OFF_W'(1);
    localparam logic [OFF_W-1:0] STEP_W = OFF_W'(2);

    logic [OFF_W-1:0] delta;

    always_comb begin
        delta = wide ? STEP_W : STEP_B;
        nxt   = dir_down ? (ptr - delta) : (ptr + delta);
    end
endmodule

// File: rtl/strx_addr_gen.sv
module strx_addr_gen #(
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int ADDR_W    = OFF_W + SEG_SHIFT
) (
    input  logic [OFF_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    input  logic              byte_idx,
    output logic [ADDR_W-1:0] addr
);
    logic [OFF_W-1:0] off_b;

    always_comb begin
        off_b = off + OFF_W'(byte_idx);
        addr  = {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off_b};
    end
endmodule

// File: rtl/strx_term.sv
module strx_term
    import strx_pkg::*;
(
    input  rep_e rep,
    input  logic sets_zf,
    input  logic zf_new,
    output logic stop
);
    always_comb begin
        unique case (rep)
            RP_NONE: stop = 1'b1;
            RP_EQ:   stop = sets_zf && !zf_new;
            RP_NE:   stop = sets_zf && zf_new;
            default: stop = 1'b0;
        endcase
    end
endmodule

// File: rtl/strx_engine.sv
module strx_engine
    import strx_pkg::*;
#(
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int BYTE_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [2:0]                  op_code,
    input  logic                        word_mode,
    input  logic [1:0]                  rep_mode,
    input  logic                        dir_down,
    input  logic                        zf_in,
    input  logic [OFF_W-1:0]            src_off_in,
    input  logic [OFF_W-1:0]            dst_off_in,
    input  logic [OFF_W-1:0]            count_in,
    input  logic [OFF_W-1:0]            src_seg_in,
    input  logic [OFF_W-1:0]            dst_seg_in,
    input  logic [2*BYTE_W-1:0]         acc_in,
    output logic                        busy,
    output logic                        done,
    output logic                        zf_out,
    output logic [OFF_W-1:0]            src_off,
    output logic [OFF_W-1:0]            dst_off,
    output logic [OFF_W-1:0]            count,
    output logic [2*BYTE_W-1:0]         acc_out,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [OFF_W+SEG_SHIFT-1:0]  mem_addr,
    output logic [BYTE_W-1:0]           mem_wdata,
    input  logic                        mem_ack,
    input  logic [BYTE_W-1:0]           mem_rdata
);
    localparam int ADDR_W = OFF_W + SEG_SHIFT;
    localparam int ACC_W  = 2 * BYTE_W;

    st_e              state;
    ph_e              ph;
    ph_e              first_ph;
    ph_e              nxt_ph;
    logic             ph_done;
    logic             idx;
    logic [2:0]       op_q;
    op_use_t          use_q;
    logic             wide_q;
    rep_e             rep_q;
    logic             df_q;
    logic             zf_q;
    logic [OFF_W-1:0] si_q, di_q, cx_q, ds_q, es_q;
    logic [ACC_W-1:0] acc_q, sbuf, dbuf;

    logic [OFF_W-1:0]  si_nxt, di_nxt;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [ACC_W-1:0]  wr_lane, cmp_a;
    logic              last, eq, zf_new, stop;

    strx_ptr_step #(.OFF_W(OFF_W)) u_si_step (
        .ptr(si_q), .wide(wide_q), .dir_down(df_q), .nxt(si_nxt));
    strx_ptr_step #(.OFF_W(OFF_W)) u_di_step (
        .ptr(di_q), .wide(wide_q), .dir_down(df_q), .nxt(di_nxt));

    strx_addr_gen #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)) u_src_addr (
        .seg(ds_q), .off(si_q), .byte_idx(idx), .addr(src_addr));
    strx_addr_gen #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)) u_dst_addr (
        .seg(es_q), .off(di_q), .byte_idx(idx), .addr(dst_addr));

    strx_term u_term (
        .rep(rep_q), .sets_zf(use_q.sets_zf), .zf_new(zf_new), .stop(stop));

    // Phase sequencing inside one element.
    always_comb begin
        if (use_q.rd_src)      first_ph = PH_SRC;
        else if (use_q.rd_dst) first_ph = PH_DRD;
        else                   first_ph = PH_DWR;

        nxt_ph  = ph;
        ph_done = 1'b1;
        if (ph == PH_SRC) begin
            if (use_q.rd_dst) begin
                nxt_ph  = PH_DRD;
                ph_done = 1'b0;
            end else if (use_q.wr_dst) begin
                nxt_ph  = PH_DWR;
                ph_done = 1'b0;
            end
        end
    end

    // Datapath: write lane, element comparison.
    always_comb begin
        last      = (idx == wide_q);
        wr_lane   = (op_q == OP_STORE) ? acc_q : sbuf;
        mem_wdata = idx ? wr_lane[ACC_W-1:BYTE_W] : wr_lane[BYTE_W-1:0];
        cmp_a     = (op_q == OP_SCAN) ? acc_q : sbuf;
        eq        = wide_q ? (cmp_a == dbuf)
                           : (cmp_a[BYTE_W-1:0] == dbuf[BYTE_W-1:0]);
        zf_new    = use_q.sets_zf ? eq : zf_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ph     <= PH_SRC;
            idx    <= 1'b0;
            op_q   <= 3'd0;
            use_q  <= '0;
            wide_q <= 1'b0;
            rep_q  <= RP_NONE;
            df_q   <= 1'b0;
            zf_q   <= 1'b0;
            si_q   <= '0;
            di_q   <= '0;
            cx_q   <= '0;
            ds_q   <= '0;
            es_q   <= '0;
            acc_q  <= '0;
            sbuf   <= '0;
            dbuf   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_q   <= op_code;
                        use_q  <= decode_op(op_code);
                        wide_q <= word_mode;
                        rep_q  <= rep_e'(rep_mode);
                        df_q   <= dir_down;
                        zf_q   <= zf_in;
                        si_q   <= src_off_in;
                        di_q   <= dst_off_in;
                        cx_q   <= count_in;
                        ds_q   <= src_seg_in;
                        es_q   <= dst_seg_in;
                        acc_q  <= acc_in;
                        state  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    idx <= 1'b0;
                    ph  <= first_ph;
                    if (rep_q == RP_NONE) begin
                        state <= ST_ACCESS;
                    end else if (cx_q == '0) begin
                        state <= ST_DONE;
                    end else begin
                        cx_q  <= cx_q - OFF_W'(1);
                        state <= ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (mem_ack) begin
                        if (ph == PH_SRC) begin
                            if (idx) sbuf[ACC_W-1:BYTE_W] <= mem_rdata;
                            else     sbuf[BYTE_W-1:0]     <= mem_rdata;
                        end
                        if (ph == PH_DRD) begin
                            if (idx) dbuf[ACC_W-1:BYTE_W] <= mem_rdata;
                            else     dbuf[BYTE_W-1:0]     <= mem_rdata;
                        end
                        if (last) begin
                            idx <= 1'b0;
                            ph  <= nxt_ph;
                            if (ph_done) state <= ST_STEP;
                        end else begin
                            idx <= 1'b1;
                        end
                    end
                end
                ST_STEP: begin
                    zf_q <= zf_new;
                    if (op_q == OP_LOAD) begin
                        if (wide_q) acc_q <= sbuf;
                        else        acc_q[BYTE_W-1:0] <= sbuf[BYTE_W-1:0];
                    end
                    if (use_q.adv_si) si_q <= si_nxt;
                    if (use_q.adv_di) di_q <= di_nxt;
                    state <= stop ? ST_DONE : ST_CHECK;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        mem_req  = (state == ST_ACCESS);
        mem_we   = mem_req && (ph == PH_DWR);
        mem_addr = (ph == PH_SRC) ? src_addr : dst_addr;
        zf_out   = zf_q;
        src_off  = si_q;
        dst_off  = di_q;
        count    = cx_q;
        acc_out  = acc_q;
    end
endmodule

// File: rtl/strx_engine_chk.sv
module strx_engine_chk #(
    parameter int OFF_W  = 16,
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [OFF_W-1:0]  src_off,
    input logic [OFF_W-1:0]  dst_off,
    input logic [OFF_W-1:0]  count
);
    function automatic logic step_ok(input logic [OFF_W-1:0] d);
        return (d == '0) || (d == OFF_W'(1)) || (d == OFF_W'(2)) ||
               (d == {OFF_W{1'b1}}) || (d == ({OFF_W{1'b1}} - OFF_W'(1)));
    endfunction

    // R9: completion is a single-cycle pulse followed by idle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R9: a pending request keeps its address and direction
    a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9: no memory traffic or completion while idle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !done));

    // R4: during a run the count only holds or drops by one
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy) |-> ((count == $past(count)) || (count == $past(count) - OFF_W'(1))));

    // R2: offsets move by at most one element per cycle
    a_r2_src_step: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy) |-> step_ok(src_off - $past(src_off)));

    a_r2_dst_step: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy) |-> step_ok(dst_off - $past(dst_off)));

    // R10: a run is never abandoned before its done cycle
    a_r10_no_abort: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
endmodule

bind strx_engine strx_engine_chk #(.OFF_W(OFF_W), .ADDR_W(OFF_W + SEG_SHIFT)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .src_off(src_off), .dst_off(dst_off), .count(count));

// File: tb/test_strx_engine.sv
module test_strx_engine;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  op_code;
    logic        word_mode;
    logic [1:0]  rep_mode;
    logic        dir_down;
    logic        zf_in;
    logic [15:0] src_off_in, dst_off_in, count_in, src_seg_in, dst_seg_in, acc_in;
    logic        busy, done, zf_out;
    logic [15:0] src_off, dst_off, count, acc_out;
    logic        mem_req, mem_we, mem_ack;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    strx_engine i_strx_engine (
        .clk(clk), .rst(rst), .start(start), .op_code(op_code), .word_mode(word_mode),
        .rep_mode(rep_mode), .dir_down(dir_down), .zf_in(zf_in),
        .src_off_in(src_off_in), .dst_off_in(dst_off_in), .count_in(count_in),
        .src_seg_in(src_seg_in), .dst_seg_in(dst_seg_in), .acc_in(acc_in),
        .busy(busy), .done(done), .zf_out(zf_out), .src_off(src_off), .dst_off(dst_off),
        .count(count), .acc_out(acc_out), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0]  dmem [int];
    logic [7:0]  rmem [int];
    logic [27:0] wq [$];
    int lat = 0;
    int lat_seq = 0;

    function automatic logic [7:0] pat(int a);
        return 8'(a * 7 + 3);
    endfunction
    function automatic int phys(int seg, int off);
        return (seg * 16 + (off & 65535)) % 1048576;
    endfunction
    function automatic logic [7:0] rd_d(int a);
        if (dmem.exists(a)) return dmem[a];
        return pat(a);
    endfunction
    function automatic logic [7:0] rd_r(int a);
        if (rmem.exists(a)) return rmem[a];
        return pat(a);
    endfunction

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic poke(int a, logic [7:0] v);
        dmem[a] = v;
        rmem[a] = v;
    endtask

    // Memory responder with a rotating latency; checks every write on acknowledge.
    initial begin
        mem_ack = 1'b0;
        mem_rdata = 8'h00;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (lat > 0) begin
                    lat--;
                end else begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        dmem[int'(mem_addr)] = mem_wdata;
                        if (wq.size() == 0) begin
                            n_cmp++;
                            n_bad++;
                            $display("FAIL R3 write order: got %0h expected none", {mem_addr, mem_wdata});
                        end else begin
                            chk("R1 R3", "write address/byte", 32'({mem_addr, mem_wdata}), 32'(wq.pop_front()));
                        end
                    end else begin
                        mem_rdata = rd_d(int'(mem_addr));
                    end
                    lat_seq = (lat_seq + 1) % 3;
                    lat = lat_seq;
                end
            end
        end
    end

    task automatic ref_elem(int op, int n, int ds, int es, int si, int di,
                            inout int acc, inout int zf);
        int s, d, msk;
        msk = (n == 2) ? 16'hFFFF : 16'h00FF;
        s = rd_r(phys(ds, si));
        d = rd_r(phys(es, di));
        if (n == 2) begin
            s = s | (int'(rd_r(phys(ds, si + 1))) << 8);
            d = d | (int'(rd_r(phys(es, di + 1))) << 8);
        end
        case (op)
            1: zf = (s == d) ? 1 : 0;
            2: zf = ((acc & msk) == d) ? 1 : 0;
            3: acc = (n == 2) ? s : ((acc & 16'hFF00) | s);
            default: begin
                for (int b = 0; b < n; b++) begin
                    int a;
                    logic [7:0] v;
                    a = phys(es, di + b);
                    v = (op == 4) ? 8'(acc >> (8 * b)) : 8'(s >> (8 * b));
                    rmem[a] = v;
                    wq.push_back({20'(a), v});
                end
            end
        endcase
    endtask

    task automatic ref_model(int op, int wide, int rep, int df, int zf0, int si0, int di0,
                             int cx0, int ds, int es, int acc0,
                             output int o_si, output int o_di, output int o_cx,
                             output int o_zf, output int o_acc);
        int n, stp, si, di, cx, zf, acc;
        bit iscmp;
        n = wide ? 2 : 1;
        stp = df ? -n : n;
        si = si0; di = di0; cx = cx0; zf = zf0; acc = acc0;
        iscmp = (op == 1 || op == 2);
        if (op > 4) op = 0;
        if (rep == 0) begin
            ref_elem(op, n, ds, es, si, di, acc, zf);
            if (op == 0 || op == 1 || op == 3) si = (si + stp) & 65535;
            if (op != 3) di = (di + stp) & 65535;
        end else begin
            while (cx != 0) begin
                cx--;
                ref_elem(op, n, ds, es, si, di, acc, zf);
                if (op == 0 || op == 1 || op == 3) si = (si + stp) & 65535;
                if (op != 3) di = (di + stp) & 65535;
                if (iscmp && rep == 2 && zf == 0) break;
                if (iscmp && rep == 3 && zf == 1) break;
            end
        end
        o_si = si; o_di = di; o_cx = cx; o_zf = zf; o_acc = acc;
    endtask

    task automatic run(string tag, int op, int wide, int rep, int df, int zf, int si, int di,
                       int cx, int ds, int es, int acc, bit interfere);
        int e_si, e_di, e_cx, e_zf, e_acc, t;
        ref_model(op, wide, rep, df, zf, si, di, cx, ds, es, acc, e_si, e_di, e_cx, e_zf, e_acc);
        @(negedge clk);
        start = 1'b1; op_code = 3'(op); word_mode = wide[0]; rep_mode = 2'(rep);
        dir_down = df[0]; zf_in = zf[0]; src_off_in = 16'(si); dst_off_in = 16'(di);
        count_in = 16'(cx); src_seg_in = 16'(ds); dst_seg_in = 16'(es); acc_in = 16'(acc);
        @(negedge clk);
        start = 1'b0;
        if (interfere) begin
            @(negedge clk);
            start = 1'b1; op_code = 3'd4; word_mode = 1'b1; rep_mode = 2'd1;
            dir_down = 1'b1; count_in = 16'h0040; acc_in = 16'hDEAD;
            src_off_in = 16'h7777; dst_off_in = 16'h0000;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 5000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R9 %s: done got 0 expected 1 (watchdog)", tag);
        end
        chk(tag, "source offset", 32'(src_off), 32'(e_si & 65535));
        chk(tag, "destination offset", 32'(dst_off), 32'(e_di & 65535));
        chk(tag, "count", 32'(count), 32'(e_cx));
        chk(tag, "zero flag", 32'(zf_out), 32'(e_zf));
        chk(tag, "accumulator", 32'(acc_out), 32'(e_acc & 65535));
        chk(tag, "writes left undone", 32'(wq.size()), 32'd0);
        wq.delete();
        @(negedge clk);
        chk("R9", "busy after done", 32'(busy), 32'd0);
        chk("R9", "done pulse width", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        string sa, sb;
        rst = 1'b1; start = 1'b0; op_code = '0; word_mode = 1'b0; rep_mode = '0;
        dir_down = 1'b0; zf_in = 1'b0; src_off_in = '0; dst_off_in = '0; count_in = '0;
        src_seg_in = '0; dst_seg_in = '0; acc_in = '0;
        repeat (3) @(negedge clk);
        chk("R9", "reset busy", 32'(busy), 32'd0);
        chk("R9", "reset done", 32'(done), 32'd0);
        chk("R9", "reset request", 32'(mem_req), 32'd0);
        chk("R9", "reset count", 32'(count), 32'd0);
        chk("R9", "reset accumulator", 32'(acc_out), 32'd0);
        rst = 1'b0;

        sa = "LANTERNS";
        sb = "LANTMRNS";
        for (int i = 0; i < 8; i++) begin
            poke(phys(16'h1200, 16'h0040 + i), sa[i]);
            poke(phys(16'h0A30, 16'h0300 + i), sb[i]);
        end

        run("R1 R2 R4 byte move upward", 0, 0, 1, 0, 0, 16'h0040, 16'h0800, 5, 16'h1200, 16'h1200, 0, 0);
        run("R2 R3 word move downward", 0, 1, 1, 1, 0, 16'h0046, 16'h0900, 3, 16'h1200, 16'h0A30, 0, 0);
        run("R4 zero count no access", 0, 0, 1, 0, 1, 16'h0040, 16'h0A00, 0, 16'h1200, 16'h1200, 0, 0);
        run("R6 R7 single compare keeps count", 1, 0, 0, 0, 0, 16'h0040, 16'h0300, 7, 16'h1200, 16'h0A30, 0, 0);
        run("R5 while-equal compare stops on mismatch", 1, 0, 2, 0, 1, 16'h0040, 16'h0300, 9, 16'h1200, 16'h0A30, 0, 0);
        run("R5 R7 while-not-equal scan finds byte", 2, 0, 3, 0, 0, 0, 16'h0300, 8, 0, 16'h0A30, 16'hAA54, 0);
        run("R5 while-equal word compare exhausts count", 1, 1, 2, 0, 0, 16'h0040, 16'h0300, 2, 16'h1200, 16'h0A30, 0, 0);
        run("R5 count end and mismatch on same element", 1, 0, 2, 0, 1, 16'h0040, 16'h0300, 5, 16'h1200, 16'h0A30, 0, 0);
        run("R5 while-not-equal compare stops on first match", 1, 0, 3, 0, 0, 16'h0040, 16'h0300, 6, 16'h1200, 16'h0A30, 0, 0);
        run("R8 byte load keeps high half", 3, 0, 0, 1, 0, 16'h0043, 0, 3, 16'h1200, 0, 16'hBEEF, 0);
        run("R8 repeated word load", 3, 1, 1, 0, 1, 16'h0040, 0, 3, 16'h1200, 0, 16'h0000, 0);
        run("R3 R7 R8 repeated word store keeps flag", 4, 1, 1, 0, 1, 0, 16'h0B00, 4, 0, 16'h0A30, 16'h1234, 0);
        run("R5 R7 conditional prefix on move acts as repeat", 0, 0, 2, 0, 0, 16'h0040, 16'h0C00, 4, 16'h1200, 16'h0A30, 0, 0);
        run("R1 R3 offset wrap inside segment", 0, 1, 0, 0, 0, 16'hFFFF, 16'hFFFF, 1, 16'h2000, 16'h3000, 0, 0);
        run("R10 start while busy ignored", 0, 0, 1, 0, 0, 16'h0040, 16'h0D00, 6, 16'h1200, 16'h0A30, 0, 1);
        run("R7 scan byte mismatch single", 2, 0, 0, 1, 1, 0, 16'h0307, 1, 0, 16'h0A30, 16'h0041, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule